// File: doc/BRIEF.md
# Transmitter Operating-Mode Sequencer

This block decides, cycle by cycle, which parts of a small sub-GHz transmitter are powered. It watches the enable pin, the shared serial-data/modulation pin, the crystal-ready flag and two strobes from the serial loader. The first strobe marks that the frame is far enough along for the synthesizer to start. The second marks that the whole frame is loaded. From these it moves through nine operating modes. It drives one enable per analog block and publishes the current mode as a 4-bit code.

Two timers live inside. The synthesizer is declared locked after a fixed number of reference-clock cycles, once the frame is loaded and the crystal is ready. A register-reset path lets the device be reprogrammed without stopping the crystal. That path is only honoured if it is held for a minimum number of cycles. A shorter hold drops the device to off.

Top module: `txmode_ctrl`

## Requirements
- R1: During and right after synchronous reset the mode code is 0 (off) and every block enable is low. Mode codes: 0 off, 1 startup-A, 2 startup-B, 3 transmit-idle, 4 transmit-active, 5 clock-only, 6 register-reset, 7 config-A, 8 config-B.
- R2: In off, enable high with data low moves to startup-A at the next edge. Enable high with data high keeps off. Enable low with data high also keeps off.
- R3: From any mode, enable low with data low gives off at the next edge.
- R4: In startup-A or config-A, with enable high, the part-done strobe with clock-only low moves to startup-B or config-B respectively. The strobe takes priority. Failing that, clock-only high with the crystal ready and the frame loaded moves to clock-only. The frame counts as loaded if the full-done strobe is high now, or was seen since the last off or register-reset mode.
- R5: In startup-B or config-B, an edge is counted when the frame is loaded and the crystal is ready. The move to transmit-idle happens at the LOCK_CYCLES-th counted edge. The count restarts from zero on every entry to these modes.
- R6: Transmit-idle moves to transmit-active when the modulation bit is 0 (FSK), or when it is 1 (ASK) and data is high. Transmit-active returns to transmit-idle only under ASK with data low. Under FSK it holds.
- R7: From any mode except off, enable low with data high gives register-reset at the next edge.
- R8: In register-reset, enable high with data low moves to config-A if the mode has lasted at least RESET_MIN_CYCLES cycles. Otherwise it moves to off.
- R9: Enables as {osc, ctl, pll, clkdrv, pa}:
  - off: none.
  - startup-A: osc, ctl.
  - startup-B: osc, ctl, pll.
  - transmit-idle: osc, ctl, pll, clkdrv.
  - transmit-active: all five.
  - clock-only, register-reset and config-A: osc, ctl, clkdrv.
  - config-B: osc, ctl, pll, clkdrv.
- R10: The clock-driver enable is high only while the clock-output bit input is high. The listed modes then show it; with the bit low it is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Device enable pin |
| data_i | input | 1 | Serial data / modulation pin |
| xtal_ready_i | input | 1 | Crystal amplitude reached |
| part_done_i | input | 1 | Strobe: frame loaded up to the band bit |
| full_done_i | input | 1 | Strobe: whole frame loaded |
| clk_only_i | input | 1 | Clock-only configuration bit |
| ask_sel_i | input | 1 | Modulation bit, 1 = ASK, 0 = FSK |
| clk_drv_bit_i | input | 1 | Clock-output enable bit |
| osc_en_o | output | 1 | Crystal oscillator enable |
| ctl_en_o | output | 1 | Digital control enable |
| pll_en_o | output | 1 | Synthesizer enable |
| clkdrv_en_o | output | 1 | Clock driver enable |
| pa_en_o | output | 1 | Power amplifier enable |
| mode_o | output | 4 | Current mode code |

## Verification
Every transition lands one edge after the inputs that cause it. The enables follow the mode code with no further delay. The bench therefore drives inputs on the falling edge and reads outputs at the next falling edge.

The two timed transitions are checked at their exact edge and one edge earlier:
- lock lands on the LOCK_CYCLES-th counted edge after the full-done strobe;
- register-reset is held for RESET_MIN_CYCLES-1 cycles, then for RESET_MIN_CYCLES cycles, before release.

The runs where lock must not come are held for longer than the full window: crystal not ready, and frame not reloaded after register-reset.

// File: rtl/txmode_pkg.sv
package txmode_pkg;

    typedef enum logic [3:0] {
        M_OFF     = 4'd0,
        M_START1  = 4'd1,
        M_START2  = 4'd2,
        M_TX1     = 4'd3,
        M_TX2     = 4'd4,
        M_CLKONLY = 4'd5,
        M_REGRST  = 4'd6,
        M_CFG1    = 4'd7,
        M_CFG2    = 4'd8
    } mode_t;

    typedef struct packed {
        logic osc;
        logic ctl;
        logic pll;
        logic clkdrv;
        logic pa;
    } blk_en_t;

    function automatic logic is_lock_mode(mode_t m);
        return (m == M_START2) || (m == M_CFG2);
    endfunction

    function automatic logic is_load_mode(mode_t m);
        return (m == M_START1) || (m == M_CFG1);
    endfunction

endpackage

// File: rtl/cycle_meter.sv
module cycle_meter #(
    parameter int LIMIT = 1280
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic armed,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (armed && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = armed && (cnt_q == LAST);

    // R5
    meter_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !hit);

endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import txmode_pkg::*;
(
    input  mode_t   mode,
    input  logic    clk_bit,
    output blk_en_t blk
);
    blk_en_t base;

    always_comb begin
        base = '0;
        case (mode)
            M_START1:                   base = '{osc: 1'b1, ctl: 1'b1, pll: 1'b0, clkdrv: 1'b0, pa: 1'b0};
            M_START2:                   base = '{osc: 1'b1, ctl: 1'b1, pll: 1'b1, clkdrv: 1'b0, pa: 1'b0};
            M_TX1, M_CFG2:              base = '{osc: 1'b1, ctl: 1'b1, pll: 1'b1, clkdrv: 1'b1, pa: 1'b0};
            M_TX2:                      base = '{osc: 1'b1, ctl: 1'b1, pll: 1'b1, clkdrv: 1'b1, pa: 1'b1};
            M_CLKONLY, M_REGRST, M_CFG1: base = '{osc: 1'b1, ctl: 1'b1, pll: 1'b0, clkdrv: 1'b1, pa: 1'b0};
            default:                    base = '0;
        endcase
    end

    always_comb begin
        blk        = base;
        blk.clkdrv = base.clkdrv & clk_bit;
    end

endmodule

// File: rtl/txmode_ctrl.sv
module txmode_ctrl
    import txmode_pkg::*;
#(
    parameter int LOCK_CYCLES      = 1280,
    parameter int RESET_MIN_CYCLES = 130
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       data_i,
    input  logic       xtal_ready_i,
    input  logic       part_done_i,
    input  logic       full_done_i,
    input  logic       clk_only_i,
    input  logic       ask_sel_i,
    input  logic       clk_drv_bit_i,
    output logic       osc_en_o,
    output logic       ctl_en_o,
    output logic       pll_en_o,
    output logic       clkdrv_en_o,
    output logic       pa_en_o,
    output logic [3:0] mode_o
);
    mode_t   state_q, state_d;
    logic    frame_q, frame_seen;
    logic    lock_hit, guard_done;
    blk_en_t blk;

    assign frame_seen = frame_q | full_done_i;

    always_ff @(posedge clk) begin
        if (rst || (state_q == M_OFF) || (state_q == M_REGRST)) begin
            frame_q <= 1'b0;
        end else if (full_done_i) begin
            frame_q <= 1'b1;
        end
    end

    cycle_meter #(.LIMIT(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .clear (!is_lock_mode(state_q)),
        .armed (is_lock_mode(state_q) && frame_seen && xtal_ready_i),
        .hit   (lock_hit)
    );

    cycle_meter #(.LIMIT(RESET_MIN_CYCLES)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q != M_REGRST),
        .armed (state_q == M_REGRST),
        .hit   (guard_done)
    );

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            if (!data_i) begin
                state_d = M_OFF;
            end else if (state_q != M_OFF) begin
                state_d = M_REGRST;
            end
        end else begin
            case (state_q)
                M_OFF: begin
                    if (!data_i) state_d = M_START1;
                end
                M_START1, M_CFG1: begin
                    if (part_done_i && !clk_only_i) begin
                        state_d = (state_q == M_START1) ? M_START2 : M_CFG2;
                    end else if (frame_seen && clk_only_i && xtal_ready_i) begin
                        state_d = M_CLKONLY;
                    end
                end
                M_START2, M_CFG2: begin
                    if (lock_hit) state_d = M_TX1;
                end
                M_TX1: begin
                    if (!ask_sel_i || data_i) state_d = M_TX2;
                end
                M_TX2: begin
                    if (ask_sel_i && !data_i) state_d = M_TX1;
                end
                M_REGRST: begin
                    if (!data_i) state_d = guard_done ? M_CFG1 : M_OFF;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= M_OFF;
        else     state_q <= state_d;
    end

    mode_decode u_dec (
        .mode    (state_q),
        .clk_bit (clk_drv_bit_i),
        .blk     (blk)
    );

    assign osc_en_o    = blk.osc;
    assign ctl_en_o    = blk.ctl;
    assign pll_en_o    = blk.pll;
    assign clkdrv_en_o = blk.clkdrv;
    assign pa_en_o     = blk.pa;
    assign mode_o      = state_q;

    // R3
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !data_i) |=> (state_q == M_OFF));

    // R7
    regrst_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && data_i && state_q != M_OFF) |=> (state_q == M_REGRST));

    // R8
    short_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_REGRST && en_i && !data_i && !guard_done) |=> (state_q == M_OFF));

    // R5
    early_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (is_lock_mode(state_q) && en_i && !lock_hit) |=> $stable(state_q));

    // R9
    pa_tx2_chk: assert property (@(posedge clk) disable iff (rst)
        pa_en_o |-> (state_q == M_TX2));

    // R10
    clkdrv_bit_chk: assert property (@(posedge clk) disable iff (rst)
        clkdrv_en_o |-> clk_drv_bit_i);

endmodule

// File: tb/txmode_ctrl_test.sv
module txmode_ctrl_test;
    localparam int LOCK = 1280;
    localparam int RMIN = 130;

    localparam logic [3:0] C_OFF = 4'd0, C_S1 = 4'd1, C_S2 = 4'd2, C_TX1 = 4'd3,
                           C_TX2 = 4'd4, C_CO = 4'd5, C_RR = 4'd6, C_C1 = 4'd7, C_C2 = 4'd8;

    logic clk = 1'b0;
    logic rst, en, data, xtal, part, full, conly, ask, cbit;
    logic osc_en, ctl_en, pll_en, clkdrv_en, pa_en;
    logic [3:0] mode;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    txmode_ctrl #(.LOCK_CYCLES(LOCK), .RESET_MIN_CYCLES(RMIN)) uut (
        .clk(clk), .rst(rst), .en_i(en), .data_i(data), .xtal_ready_i(xtal),
        .part_done_i(part), .full_done_i(full), .clk_only_i(conly), .ask_sel_i(ask),
        .clk_drv_bit_i(cbit), .osc_en_o(osc_en), .ctl_en_o(ctl_en), .pll_en_o(pll_en),
        .clkdrv_en_o(clkdrv_en), .pa_en_o(pa_en), .mode_o(mode)
    );

    // R9 R10: expected {osc,ctl,pll,clkdrv,pa} from the mode table
    function automatic logic [4:0] exp_en(input logic [3:0] m, input logic b);
        case (m)
            C_S1:             return 5'b11000;
            C_S2:             return 5'b11100;
            C_TX1, C_C2:      return {3'b111, b, 1'b0};
            C_TX2:            return {3'b111, b, 1'b1};
            C_CO, C_RR, C_C1: return {3'b110, b, 1'b0};
            default:          return 5'b00000;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_mode(input logic [3:0] m, input string tag);
        logic [4:0] act_en;
        logic [4:0] want_en;
        act_en  = {osc_en, ctl_en, pll_en, clkdrv_en, pa_en};
        want_en = exp_en(m, cbit);
        checks++;
        if (mode !== m || act_en !== want_en) begin
            failures++;
            $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
                     tag, mode, act_en, m, want_en);
        end
    endtask

    task automatic hold_reset(input int h);
        en = 1'b0; data = 1'b1;
        repeat (h) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 0; data = 0; xtal = 0; part = 0; full = 0;
        conly = 0; ask = 0; cbit = 1;
        repeat (3) step();
        expect_mode(C_OFF, "R1 during reset");
        rst = 1'b0;
        step();
        expect_mode(C_OFF, "R1 after reset");

        data = 1; step(); expect_mode(C_OFF, "R2 off ignores en0 data1");
        en = 1;   step(); expect_mode(C_OFF, "R2 off ignores en1 data1");
        data = 0; step(); expect_mode(C_S1,  "R2 startup-A entry");

        xtal = 1; part = 1; step(); part = 0;
        expect_mode(C_S2, "R4 part strobe to startup-B");
        full = 1; step(); full = 0;
        repeat (LOCK - 2) step();
        expect_mode(C_S2, "R5 one edge before lock");
        step(); expect_mode(C_TX1, "R5 lock edge");
        step(); expect_mode(C_TX2, "R6 fsk to active");
        repeat (3) step(); expect_mode(C_TX2, "R6 fsk holds with data low");
        cbit = 0; #1 expect_mode(C_TX2, "R10 clock driver off with bit low");
        cbit = 1;

        hold_reset(RMIN - 1);
        expect_mode(C_RR, "R7 register-reset entry");
        en = 1; data = 0; step();
        expect_mode(C_OFF, "R8 short reset falls to off");

        step(); expect_mode(C_S1, "R2 startup-A again");
        hold_reset(RMIN);
        expect_mode(C_RR, "R7 from startup-A");
        en = 1; data = 0; step();
        expect_mode(C_C1, "R8 long reset to config-A");

        conly = 1; full = 1; step(); full = 0;
        expect_mode(C_CO, "R4 full frame to clock-only");
        cbit = 0; #1 expect_mode(C_CO, "R10 clock-only with bit low");
        cbit = 1; data = 1; repeat (2) step();
        expect_mode(C_CO, "R4 clock-only holds");
        en = 0; data = 0; step(); expect_mode(C_OFF, "R3 clock-only to off");

        conly = 0; xtal = 0; en = 1; step(); expect_mode(C_S1, "R2 startup-A third");
        part = 1; step(); part = 0; expect_mode(C_S2, "R4 startup-B again");
        full = 1; step(); full = 0;
        repeat (LOCK + 5) step();
        expect_mode(C_S2, "R5 no lock without crystal");

        hold_reset(RMIN);
        en = 1; data = 0; step(); expect_mode(C_C1, "R8 config-A second");
        xtal = 1; part = 1; step(); part = 0;
        expect_mode(C_C2, "R4 part strobe to config-B");
        repeat (LOCK + 5) step();
        expect_mode(C_C2, "R5 no lock until frame reloaded");
        full = 1; step(); full = 0;
        repeat (LOCK - 2) step();
        expect_mode(C_C2, "R5 restart one edge early");
        ask = 1;
        step(); expect_mode(C_TX1, "R5 restarted lock edge");
        step(); expect_mode(C_TX1, "R6 ask idle with data low");
        data = 1; step(); expect_mode(C_TX2, "R6 ask data high");
        cbit = 0; #1 expect_mode(C_TX2, "R10 active with bit low");
        cbit = 1;
        data = 0; step(); expect_mode(C_TX1, "R6 ask data low");
        data = 1; step(); expect_mode(C_TX2, "R6 ask data high again");
        en = 0; data = 0; step(); expect_mode(C_OFF, "R3 active to off");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule